// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over a fixed run of clock cycles and returns the full 64-bit product as a high word and a low word. A one-cycle `start` pulse accepts the operands and a mode flag. The flag chooses between an unsigned product and a two's-complement signed product. The unit raises `busy` while it works. It pulses `done` for one cycle when `res_hi`/`res_lo` carry the new result. The result words keep their value until the next operation completes.

One 2W-bit register does two jobs. Its upper half accumulates the partial product. Its lower half starts out holding the multiplier, whose bits are consumed from the bottom. On each iteration the unit tests the register's least significant bit. If the bit is set, it adds the multiplicand to the upper half. In the same cycle it shifts the whole register right by one, and the carry of that add enters at the top. Signed products work on magnitudes: one cycle converts the operands to magnitudes, W cycles multiply, and one cycle negates the 2W-bit result when the operand signs differed.

The controller has four states:
- `ST_IDLE` waits for `start`, latches the operands and the mode, and goes to `ST_CONV`.
- `ST_CONV` loads the magnitudes and the result sign, and goes to `ST_ITER`.
- `ST_ITER` runs W add/shift steps and leaves after the last one for `ST_FIX`.
- `ST_FIX` applies the sign, writes the result words, pulses `done`, and returns to `ST_IDLE`.

Top module: `mul_seq_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `res_hi`/`res_lo` are 0.
- R2: With `is_signed`=0, {`res_hi`,`res_lo`} equals the unsigned 64-bit product of `opnd_a` and `opnd_b`. For example, 21 × 5 gives `res_hi`=0 and `res_lo`=105.
- R3: With `is_signed`=1, {`res_hi`,`res_lo`} equals the 64-bit two's-complement product of the operands, read as two's-complement 32-bit values.
- R4: In signed mode, an operand of -2^31 (0x80000000) gives the correct product. (-2^31)×(-2^31) = 0x40000000_00000000 and (-2^31)×1 = 0xFFFFFFFF_80000000.
- R5: `done` rises on the 35th rising clock edge, counting as the first the edge that samples `start` in idle. This holds for every operand value and for both modes.
- R6: `done` stays high for exactly one cycle. `busy` is 1 from the cycle after `start` is accepted until `done` rises, and `busy` and `done` are never both 1.
- R7: A `start` pulse while `busy` is 1 has no effect. The result belongs to the first operands, and the latency of R5 is unchanged.
- R8: `res_hi`/`res_lo` change only together with a `done` pulse, and they hold their value while operand inputs change between operations.
- R9: The carry out of each add is not lost. For example, 0xFFFFFFFF × 0xFFFFFFFF unsigned gives 0xFFFFFFFE_00000001.
- R10: With `is_signed`=0, a set top bit means magnitude, not sign. For example, 0x80000000 × 2 gives `res_hi`=1 and `res_lo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiply |
| opnd_a | input | 32 | Multiplicand |
| opnd_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: new result is valid |
| res_hi | output | 32 | Upper 32 bits of the product |
| res_lo | output | 32 | Lower 32 bits of the product |

## Verification
The small unsigned case 21 × 5 confirms the basic add-when-set, shift-right order. All-ones operands exercise the carry into the top bit, and 0x80000000 × 2 in unsigned mode shows that a set top bit is not taken as a sign. Signed pairs cover each mix of operand signs, so the negation step shows up both when it is needed and when it is not. The -2^31 cases separate a correct magnitude path from one that overflows. A start pulse injected mid-run and a quiet period with changing inputs show that neither disturbs the operation in flight or the held result.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_ITER = 2'd2,
        ST_FIX  = 2'd3
    } mul_state_e;
endpackage

// File: rtl/mul_sign_unit.sv
module mul_sign_unit #(
    parameter int W = 32
) (
    input  logic         signed_en,
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b_raw,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         neg_res
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg   = signed_en & a_raw[W-1];
        b_neg   = signed_en & b_raw[W-1];
        // -2^(W-1) maps onto itself, which read as unsigned is 2^(W-1).
        a_mag   = a_neg ? (~a_raw + W'(1)) : a_raw;
        b_mag   = b_neg ? (~b_raw + W'(1)) : b_raw;
        neg_res = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    logic [W-1:0] mcand_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod    <= '0;
            mcand_q <= '0;
        end else if (load) begin
            prod    <= {{W{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
        end else if (step) begin
            prod    <= {sum, prod[W-1:1]};
        end
    end

    // While the register is loaded, the multiplicand must not move.
    AST_MCAND_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q)); // R2
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] mag_prod,
    input  logic           negate,
    output logic [2*W-1:0] result
);
    always_comb begin
        result = negate ? (~mag_prod + (2*W)'(1)) : mag_prod;
    end

    // A product of two magnitudes of at most 2^(W-1) never reaches the sign bit.
    AST_NEG_SIGN: assert final ((negate && mag_prod != '0) ? result[2*W-1] : 1'b1); // R3
endmodule

// File: rtl/mul_seq_unit.sv
module mul_seq_unit
    import mul_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        is_signed,
    output logic        busy,
    output logic        done,
    output logic [31:0] res_hi,
    output logic [31:0] res_lo
);
    localparam int W     = 32;
    localparam int CNT_W = $clog2(W) + 1;

    mul_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     a_q, b_q;
    logic             sgn_q, neg_q;
    logic [W-1:0]     a_mag, b_mag;
    logic             neg_c;
    logic [2*W-1:0]   prod, fixed;
    logic             last_step;

    mul_sign_unit #(.W(W)) u_sign (
        .signed_en (sgn_q),
        .a_raw     (a_q),
        .b_raw     (b_q),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .neg_res   (neg_c)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == ST_CONV),
        .step      (state == ST_ITER),
        .mcand_in  (a_mag),
        .mplier_in (b_mag),
        .prod      (prod)
    );

    mul_result_fix #(.W(W)) u_fix (
        .mag_prod (prod),
        .negate   (neg_q),
        .result   (fixed)
    );

    assign last_step = (cnt == CNT_W'(W - 1));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_CONV;
            ST_CONV: nxt = ST_ITER;
            ST_ITER: if (last_step) nxt = ST_FIX;
            ST_FIX:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Operand capture, sign and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
            neg_q <= 1'b0;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q   <= opnd_a;
                        b_q   <= opnd_b;
                        sgn_q <= is_signed;
                    end
                end
                ST_CONV: begin
                    neg_q <= neg_c;
                    cnt   <= '0;
                end
                ST_ITER: cnt <= cnt + CNT_W'(1);
                ST_FIX:  ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            res_hi <= '0;
            res_lo <= '0;
        end else begin
            done <= (state == ST_FIX);
            if (state == ST_FIX) begin
                res_hi <= fixed[2*W-1:W];
                res_lo <= fixed[W-1:0];
            end
        end
    end

    assign busy = (state != ST_IDLE);

    AST_ITER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> (cnt == CNT_W'(W))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R6
    AST_OPND_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_FIX) |=> $stable({a_q, b_q, sgn_q})); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable({res_hi, res_lo})); // R8
endmodule

// File: tb/test_mul_seq_unit.sv
module test_mul_seq_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        is_signed = 1'b0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mul_seq_unit i_mul_seq_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .is_signed(is_signed),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic s);
        logic signed [63:0] sa, sb;
        if (s) begin
            sa = {{32{a[31]}}, a};
            sb = {{32{b[31]}}, b};
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    // Runs one multiply; optional start pulse with other operands mid-run.
    task automatic run_mul(logic [31:0] a, logic [31:0] b, logic s,
                           bit inject, output int cycles);
        @(negedge clk);
        opnd_a = a; opnd_b = b; is_signed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        check("R6 busy after start", 64'(busy), 64'd1);
        while (!done && cycles < 200) begin
            if (inject && cycles == 6) begin
                opnd_a = ~a; opnd_b = b + 32'd3; is_signed = ~s; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        check("R6 busy low with done", 64'(busy), 64'd0);
        @(negedge clk);
        check("R6 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_op(string req, logic [31:0] a, logic [31:0] b, logic s);
        int cyc;
        run_mul(a, b, s, 1'b0, cyc);
        check(req, {res_hi, res_lo}, ref_mul(a, b, s));
        check("R5 latency", 64'(cyc), 64'd35);
    endtask

    task automatic t_reset();
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 result", {res_hi, res_lo}, 64'd0);
    endtask

    task automatic t_fixed_values();
        int cyc;
        run_mul(32'd21, 32'd5, 1'b0, 1'b0, cyc);
        check("R2 21x5", {res_hi, res_lo}, 64'd105);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, cyc);
        check("R9 carry", {res_hi, res_lo}, 64'hFFFF_FFFE_0000_0001);
        run_mul(32'h8000_0000, 32'd2, 1'b0, 1'b0, cyc);
        check("R10 unsigned top bit", {res_hi, res_lo}, 64'h1_0000_0000);
        run_mul(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, cyc);
        check("R4 min x min", {res_hi, res_lo}, 64'h4000_0000_0000_0000);
        run_mul(32'h8000_0000, 32'd1, 1'b1, 1'b0, cyc);
        check("R4 min x 1", {res_hi, res_lo}, 64'hFFFF_FFFF_8000_0000);
        check("R5 latency", 64'(cyc), 64'd35);
    endtask

    task automatic t_busy_start();
        int cyc;
        run_mul(32'd1234567, 32'hFFFF_FFF9, 1'b1, 1'b1, cyc);
        check("R7 start ignored result", {res_hi, res_lo},
              ref_mul(32'd1234567, 32'hFFFF_FFF9, 1'b1));
        check("R7 latency unchanged", 64'(cyc), 64'd35);
    endtask

    task automatic t_hold();
        logic [63:0] held;
        held = {res_hi, res_lo};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            opnd_a = 32'(i * 77); opnd_b = 32'(i + 9); is_signed = i[0];
        end
        check("R8 result held", {res_hi, res_lo}, held);
        check("R8 no done", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed_values();
        t_op("R2 unsigned", 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
        t_op("R2 unsigned zero", 32'h0, 32'hFFFF_0000, 1'b0);
        t_op("R3 pos x neg", 32'd1000, 32'hFFFF_FFFD, 1'b1);
        t_op("R3 neg x pos", 32'hFFFF_F000, 32'd12345, 1'b1);
        t_op("R3 neg x neg", 32'h8765_4321, 32'hF000_000F, 1'b1);
        t_op("R3 pos x pos", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
        t_op("R4 min x -1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        t_busy_start();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule